// File: doc/BRIEF.md
# Serial Access-Pattern Unlock Controller

This block sits between a host bus and a byte-wide memory. It watches the host's active-low chip-enable, output-enable and write-enable strobes, and bit 0 of the data bus. While locked it is transparent: the memory chip enable follows the host chip enable. It also tracks writes, looking for a 64-bit key that the host sends one bit per write cycle, bit 0 first. A read cycle rewinds the key pointer. A wrong bit freezes the pointer until the next read.

Once the whole key has matched, the block takes the memory off the bus. It then treats the next 64 selected bus cycles as a bit-serial transfer over eight 8-bit registers. A read cycle drives the next stored bit onto data line 0. A write cycle shifts a host bit in. When the window ends, or on a power-fail pulse, the block goes back to watching for the key. The registers also have a synchronous side port, so that other logic (for example a time counter) can load and read them.

Each bus cycle is recognised at the rising edge of its strobe. The strobes are first passed through a synchroniser to the block clock.

Top module: `serial_unlock_ctrl`

## Requirements
- R1: While locked, `mem_ce_no` equals `ce_ni` and `dq0_oe_o` stays low.
- R2: A read cycle while locked resets the key pointer to bit 0 and clears any mismatch. A read cycle is `ce_ni` and `oe_ni` both low, ended by `oe_ni` rising.
- R3: A write cycle while locked compares `dq0_i` with key bit `KEY[ptr]`. On a match the pointer advances. After 64 matching writes in a row the block enters access mode. A write cycle is `ce_ni` and `we_ni` both low, ended by `we_ni` rising.
- R4: A mismatching write stops the pointer. Every later write is ignored until a read cycle, so a later correct key tail does not unlock.
- R5: In access mode `mem_ce_no` is held high for the whole 64-cycle window, including while `ce_ni` is low.
- R6: In access mode a read cycle presents register bit `regs[n/8][n%8]` for transfer cycle n on `dq0_o`. `dq0_oe_o` is high only while `ce_ni` and `oe_ni` are low in access mode.
- R7: In access mode a write cycle shifts `dq0_i` in, least significant bit first, registers in index order 0 to 7. A register changes only when its eighth bit arrives.
- R8: Access mode ends after 64 transfer cycles, and the block returns to locked matching from bit 0.
- R9: `pwr_fail_i` high for one clock leaves access mode at once and resets the key pointer. A register whose eighth bit has not arrived is left unchanged.
- R10: Strobe activity while `ce_ni` is high neither moves the key pointer nor counts as a transfer cycle.
- R11: `side_we_i` writes `side_wdata_i` into register `side_idx_i` on the clock. `side_rdata_o` shows register `side_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_fail_i | input | 1 | Power-fail indication, forces exit from access mode |
| ce_ni | input | 1 | Host chip enable, active low |
| oe_ni | input | 1 | Host output enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| dq0_i | input | 1 | Host data line 0 |
| dq0_o | output | 1 | Serial read bit for data line 0 |
| dq0_oe_o | output | 1 | Drive enable for dq0_o |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| side_we_i | input | 1 | Side-port register write strobe |
| side_idx_i | input | 3 | Side-port register index |
| side_wdata_i | input | 8 | Side-port write data |
| side_rdata_o | output | 8 | Side-port read data |

## Verification
The bench sends one wrong bit partway through the key and then finishes with the correct tail. A design that let a mismatch keep matching, or that restarted on a write, would unlock and pull `mem_ce_no` high. It also aborts a key with a read and then sends only the remaining key bits. A design that did not rewind on reads would unlock on that stray tail.

During both the key and the transfer it mixes in cycles that have chip enable high and toggle the strobes with wrong data. Counting those would shift the bytes or end the window early. A power-fail pulse in the middle of a byte checks that a partial write never reaches the register. Whole-byte reads and writes fix the bit order and the register order.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int unsigned KEY_BITS_D = 64;
  localparam logic [KEY_BITS_D-1:0] KEY_D = 64'hC3A5_5A3C_9E61_17E8;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq;
  } bus_smp_t;

  localparam bus_smp_t BUS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq: 1'b0};
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
  import unlock_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic dq_i,
  output logic rd_evt_o,
  output logic wr_evt_o,
  output logic bit_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  bus_smp_t raw;
  bus_smp_t stg [DEPTH];
  bus_smp_t cur, prv;

  assign raw = '{ce_n: ce_ni, oe_n: oe_ni, we_n: we_ni, dq: dq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= BUS_IDLE;
    end else begin
      stg[0] <= raw;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign cur = stg[SYNC_STAGES-1];
  assign prv = stg[SYNC_STAGES];

  // cycle ends on strobe rise while chip enable was still low
  assign rd_evt_o = !prv.ce_n && !prv.oe_n && cur.oe_n;
  assign wr_evt_o = !prv.ce_n && !prv.we_n && cur.we_n;
  assign bit_o    = prv.dq;
endmodule

// File: rtl/key_match.sv
module key_match #(
  parameter int unsigned KEY_BITS = 64,
  parameter logic [KEY_BITS-1:0] KEY = '0,
  localparam int unsigned PTR_W = $clog2(KEY_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             rd_evt_i,
  input  logic             wr_evt_i,
  input  logic             bit_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             fail_o,
  output logic             hit_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_BITS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             fail_q;
  logic             match;

  assign match = en_i && wr_evt_i && !fail_q && (bit_i == KEY[ptr_q]);
  assign hit_o = match && (ptr_q == LAST) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      fail_q <= 1'b0;
    end else if (clr_i || (en_i && rd_evt_i)) begin
      ptr_q  <= '0;
      fail_q <= 1'b0;
    end else if (en_i && wr_evt_i && !fail_q) begin
      if (!match)              fail_q <= 1'b1;
      else if (ptr_q == LAST)  ptr_q  <= '0;
      else                     ptr_q  <= ptr_q + 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGS),
  localparam int unsigned BIT_W = $clog2(REG_W),
  localparam int unsigned CNT_W = IDX_W + BIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             rd_evt_i,
  input  logic             wr_evt_i,
  input  logic             bit_i,
  input  logic             side_we_i,
  input  logic [IDX_W-1:0] side_idx_i,
  input  logic [REG_W-1:0] side_wdata_i,
  output logic [REG_W-1:0] side_rdata_o,
  output logic             active_o,
  output logic             rd_bit_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(NUM_REGS * REG_W - 1);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(REG_W - 1);

  logic [REG_W-1:0] regs [NUM_REGS];
  logic [REG_W-1:0] shf_q, shf_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, dirty_q;
  logic [IDX_W-1:0] idx;
  logic [BIT_W-1:0] bpos;
  logic             acc_evt, in_bit, byte_done, commit;

  assign idx      = cnt_q[CNT_W-1:BIT_W];
  assign bpos     = cnt_q[BIT_W-1:0];
  assign rd_bit_o = regs[idx][bpos];

  assign acc_evt   = active_q && !abort_i && (rd_evt_i || wr_evt_i);
  // read cycles re-shift the stored bit so mixed bytes keep unwritten bits
  assign in_bit    = wr_evt_i ? bit_i : rd_bit_o;
  assign shf_nxt   = {in_bit, shf_q[REG_W-1:1]};
  assign byte_done = acc_evt && (bpos == BIT_TOP);
  assign commit    = byte_done && (dirty_q || wr_evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dirty_q  <= 1'b0;
      shf_q    <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      dirty_q  <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      dirty_q  <= 1'b0;
    end else if (acc_evt) begin
      shf_q   <= shf_nxt;
      dirty_q <= byte_done ? 1'b0 : (dirty_q || wr_evt_i);
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (commit) begin
      regs[idx] <= shf_nxt;
    end else if (side_we_i) begin
      regs[side_idx_i] <= side_wdata_i;
    end
  end

  assign side_rdata_o = regs[side_idx_i];
  assign active_o     = active_q;
  assign cnt_o        = cnt_q;
endmodule

// File: rtl/serial_unlock_ctrl.sv
module serial_unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int unsigned KEY_BITS    = KEY_BITS_D,
  parameter logic [KEY_BITS-1:0] KEY = KEY_D,
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_fail_i,
  input  logic             ce_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic             dq0_i,
  output logic             dq0_o,
  output logic             dq0_oe_o,
  output logic             mem_ce_no,
  input  logic             side_we_i,
  input  logic [IDX_W-1:0] side_idx_i,
  input  logic [REG_W-1:0] side_wdata_i,
  output logic [REG_W-1:0] side_rdata_o
);
  localparam int unsigned PTR_W = $clog2(KEY_BITS);
  localparam int unsigned CNT_W = IDX_W + $clog2(REG_W);

  logic             rd_evt, wr_evt, ser_bit;
  logic             active, key_hit, key_fail;
  logic [PTR_W-1:0] key_ptr;
  logic [CNT_W-1:0] xfer_cnt;

  strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .dq_i     (dq0_i),
    .rd_evt_o (rd_evt),
    .wr_evt_o (wr_evt),
    .bit_o    (ser_bit)
  );

  key_match #(.KEY_BITS(KEY_BITS), .KEY(KEY)) u_match (
    .clk_i, .rst_ni,
    .en_i     (!active),
    .clr_i    (pwr_fail_i),
    .rd_evt_i (rd_evt),
    .wr_evt_i (wr_evt),
    .bit_i    (ser_bit),
    .ptr_o    (key_ptr),
    .fail_o   (key_fail),
    .hit_o    (key_hit)
  );

  xfer_engine #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_xfer (
    .clk_i, .rst_ni,
    .start_i      (key_hit),
    .abort_i      (pwr_fail_i),
    .rd_evt_i     (rd_evt),
    .wr_evt_i     (wr_evt),
    .bit_i        (ser_bit),
    .side_we_i, .side_idx_i, .side_wdata_i, .side_rdata_o,
    .active_o     (active),
    .rd_bit_o     (dq0_o),
    .cnt_o        (xfer_cnt)
  );

  assign mem_ce_no = active ? 1'b1 : ce_ni;
  assign dq0_oe_o  = active && !ce_ni && !oe_ni;
endmodule

// File: rtl/unlock_chk.sv
module unlock_chk #(
  parameter int unsigned PTR_W = 6,
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_fail_i,
  input logic             rd_evt,
  input logic             wr_evt,
  input logic             active,
  input logic             key_hit,
  input logic             key_fail,
  input logic [PTR_W-1:0] key_ptr,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic             mem_ce_no,
  input logic             dq0_oe_o
);
  a_r2_read_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt && !active |=> key_ptr == '0 && !key_fail);

  a_r3_match_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt && !active && !key_fail && !pwr_fail_i |=>
      (key_ptr == PTR_W'($past(key_ptr) + 1'b1)) || key_fail || active);

  a_r4_fail_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_fail && !rd_evt && !pwr_fail_i && !active |=> key_fail && $stable(key_ptr));

  a_r5_hit_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit && !pwr_fail_i |=> active && xfer_cnt == '0 && mem_ce_no);

  a_r6_drive_in_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq0_oe_o |-> mem_ce_no);

  a_r9_pwr_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !active && key_ptr == '0);

  a_r10_idle_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !rd_evt && !wr_evt && !pwr_fail_i |=> active && $stable(xfer_cnt));
endmodule

bind serial_unlock_ctrl unlock_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .pwr_fail_i, .rd_evt, .wr_evt, .active, .key_hit,
  .key_fail, .key_ptr, .xfer_cnt, .mem_ce_no, .dq0_oe_o
);

// File: tb/sim_serial_unlock_ctrl.sv
`timescale 1ns/1ps
module sim_serial_unlock_ctrl;
  localparam logic [63:0] TB_KEY = 64'h0F1E_2D3C_4B5A_6978;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq = 1'b0;
  logic sd_we = 1'b0;
  logic [2:0] sd_idx = '0;
  logic [7:0] sd_wd = '0;
  logic dq_o, dq_oe, mce;
  logic [7:0] sd_rd;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  serial_unlock_ctrl #(.KEY(TB_KEY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_fail_i(pwr),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n), .dq0_i(dq),
    .dq0_o(dq_o), .dq0_oe_o(dq_oe), .mem_ce_no(mce),
    .side_we_i(sd_we), .side_idx_i(sd_idx), .side_wdata_i(sd_wd),
    .side_rdata_o(sd_rd)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // selected = chip enable low; samples outputs mid-cycle
  task automatic bus(input logic is_rd, input logic sel, input logic d,
                     output logic rb, output logic roe, output logic rce);
    ce_n = !sel; dq = d;
    if (is_rd) oe_n = 1'b0; else we_n = 1'b0;
    wait_clk(4);
    rb = dq_o; roe = dq_oe; rce = mce;
    oe_n = 1'b1; we_n = 1'b1;
    wait_clk(4);
    ce_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic wr(input logic d, output logic rce);
    logic b, o;
    bus(1'b0, 1'b1, d, b, o, rce);
  endtask

  task automatic rd(output logic b, output logic o, output logic rce);
    bus(1'b1, 1'b1, 1'b0, b, o, rce);
  endtask

  task automatic noise();
    logic b, o, c;
    bus(1'b0, 1'b0, 1'b1, b, o, c);
    bus(1'b1, 1'b0, 1'b0, b, o, c);
  endtask

  task automatic send_key(input int lo, input int hi, input logic with_noise);
    logic c;
    for (int i = lo; i <= hi; i++) begin
      wr(TB_KEY[i], c);
      if (with_noise && (i % 16 == 5)) noise();
    end
  endtask

  task automatic unlock();
    logic b, o, c;
    rd(b, o, c);
    send_key(0, 63, 1'b0);
  endtask

  // locked probe: selected write must reach memory
  task automatic expect_locked(input string req);
    logic c;
    wr(1'b0, c);
    chk(c == 1'b0, req, c, 0);
  endtask

  task automatic side_set(input int i, input logic [7:0] v);
    sd_idx = 3'(i); sd_wd = v; sd_we = 1'b1;
    wait_clk(1);
    sd_we = 1'b0;
  endtask

  task automatic side_get(input int i, output logic [7:0] v);
    sd_idx = 3'(i);
    #1;
    v = sd_rd;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic b, o, c;
    chk(mce == 1'b1 && dq_oe == 1'b0, "R1 reset idle", {mce, dq_oe}, 2'b10);
    side_get(0, v);
    chk(v == 8'h00, "R11 reset regs", v, 0);
    rd(b, o, c);
    chk(c == 1'b0 && o == 1'b0, "R1 passthrough read", {c, o}, 0);
  endtask

  task automatic t_side();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) side_set(i, 8'(8'h3C ^ (i * 8'h11)));
    for (int i = 0; i < 8; i++) begin
      side_get(i, v);
      chk(v == 8'(8'h3C ^ (i * 8'h11)), "R11 side port", v, 8'(8'h3C ^ (i * 8'h11)));
    end
  endtask

  task automatic t_read_xfer();
    logic b, o, c;
    logic [7:0] got;
    logic all_oe, all_ce;
    unlock();
    all_oe = 1'b1; all_ce = 1'b1;
    for (int r = 0; r < 8; r++) begin
      got = '0;
      for (int k = 0; k < 8; k++) begin
        rd(b, o, c);
        got[k] = b;
        all_oe &= o; all_ce &= c;
        if (r == 3 && k == 2) noise();
      end
      chk(got == 8'(8'h3C ^ (r * 8'h11)), "R6 serial read byte", got, 8'(8'h3C ^ (r * 8'h11)));
    end
    chk(all_oe, "R6 drive enable on reads", all_oe, 1);
    chk(all_ce, "R5 memory off during reads", all_ce, 1);
    expect_locked("R8 exit after 64 reads");
  endtask

  task automatic t_write_xfer();
    logic c, all_ce;
    logic [7:0] v, e;
    unlock();
    all_ce = 1'b1;
    for (int r = 0; r < 8; r++) begin
      e = 8'(8'hA5 + r * 8'h17);
      for (int k = 0; k < 8; k++) begin
        wr(e[k], c);
        all_ce &= c;
        if (r == 5 && k == 6) noise();
      end
    end
    chk(all_ce, "R5 memory off during writes", all_ce, 1);
    for (int r = 0; r < 8; r++) begin
      side_get(r, v);
      e = 8'(8'hA5 + r * 8'h17);
      chk(v == e, "R7 serial write byte", v, e);
    end
    expect_locked("R8 exit after 64 writes");
  endtask

  task automatic t_mismatch();
    logic b, o, c;
    rd(b, o, c);
    send_key(0, 9, 1'b0);
    wr(!TB_KEY[10], c);
    send_key(11, 63, 1'b0);
    expect_locked("R4 mismatch blocks unlock");
    rd(b, o, c);
    send_key(0, 63, 1'b1);
    wr(1'b0, c);
    chk(c == 1'b1, "R3 unlock with noise R10", c, 1);
    pwr = 1'b1; wait_clk(1); pwr = 1'b0; wait_clk(1);
  endtask

  task automatic t_read_abort();
    logic b, o, c;
    rd(b, o, c);
    send_key(0, 29, 1'b0);
    rd(b, o, c);
    chk(c == 1'b0, "R2 read during match reaches memory", c, 0);
    send_key(30, 63, 1'b0);
    expect_locked("R2 read rewinds pointer");
  endtask

  task automatic t_pwr_fail();
    logic c;
    logic [7:0] v;
    unlock();
    wr(1'b0, c);
    chk(c == 1'b1, "R5 access entered", c, 1);
    for (int k = 1; k < 5; k++) wr(1'b0, c);
    pwr = 1'b1; wait_clk(1); pwr = 1'b0; wait_clk(1);
    side_get(0, v);
    e_chk: chk(v == 8'hA5, "R9 partial byte discarded", v, 8'hA5);
    expect_locked("R9 power fail exits");
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_side();
    t_read_xfer();
    t_write_xfer();
    t_mismatch();
    t_read_abort();
    t_pwr_fail();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule